// File: doc/BRIEF.md
# Multi-phase byte clock generator

This block takes one free-running fast oscillator clock (nominally 250 MHz, 4 ns) and derives the slower clocks of a serial transmit path. Every output comes from one phase counter that wraps every 20 oscillator cycles. The edge relationships between the outputs are therefore fixed by construction, and each output is a registered decode of the counter, so none can glitch.

The derived clocks are:
- a bit clock at half the oscillator rate;
- a byte-rate load strobe that moves only on falling bit-clock edges;
- five byte clocks with a 50% duty cycle, spaced 2 or 4 oscillator cycles apart as chosen by a select pin;
- a symbol clock at twice the byte rate, high for 40% of its period.

The block has no data stream: only a clock, a reset and a static select go in, and only clocks come out. No valid/ready handshake applies.

The byte clocks can be used to stagger strobes across boards. When the select pin changes, the new spacing is adopted only at the start of a byte period. Until then, every byte clock keeps the spacing it already had.

In the requirements, "decoded count d" is the counter value that the outputs reflect. After reset is released, the outputs after the n-th rising edge reflect decoded count (n−1) mod 20.

Top module: `byteclk_gen`

## Requirements
- R1: While `osc_rst` is high, every output is low and the phase counter is held at 0. The next decoded count after release is 0.
- R2: `bit_clk` is high at odd decoded counts and low at even ones, so it changes level on every oscillator cycle.
- R3: `byte_clk[0]` is high for decoded counts 0..9 and low for 10..19. Its first rising edge comes on the first oscillator edge after reset is released.
- R4: With the narrow spacing latched, `byte_clk[k]` (bit k, k = 0..4) is high when ((d − 2k) mod 20) < 10. For example, all five are high at d = 9, and the pattern {byte_clk[4..0]} is 5'b11100 at d = 12.
- R5: With the wide spacing latched, `byte_clk[k]` is high when ((d − 4k) mod 20) < 10. For example, {byte_clk[4..0]} is 5'b01110 at d = 12.
- R6: `phase_wide` is sampled only when the decoded count is 0. A change at any other count has no effect on `byte_clk` until the next decoded count 0.
- R7: `sym_clk` has a 10-cycle period and is high for decoded counts where (d mod 10) is 6..9 (4 high, 6 low). Its falling edges coincide with both edges of `byte_clk[0]`.
- R8: `load_strobe` is high when ((d + 2) mod 20) < 10, which means it leads `byte_clk[0]` by 2 cycles. It changes level only together with a falling edge of `bit_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| osc_rst | input | 1 | Active-high reset; stops and reinitialises the divider |
| phase_wide | input | 1 | 0 selects the 2-cycle byte clock spacing, 1 selects the 4-cycle spacing |
| bit_clk | output | 1 | Bit clock at half the oscillator rate |
| load_strobe | output | 1 | Byte-rate load strobe, 2 cycles ahead of byte_clk[0] |
| byte_clk | output | 5 | Five byte clocks, bit k offset by k spacings |
| sym_clk | output | 1 | Symbol clock at twice the byte rate, 40% high |

## Verification
The bench builds the block with its defaults: a 20-cycle byte period, five byte clocks, and spacings of 2 and 4. With these values the widest offset (16 cycles) puts the last byte clock high across the counter wrap. Both spacing changes at count 0 then cut one of its phases short, and the bench checks those cycles against the spacing in force. A per-cycle model compares every output on every cycle through resets, mid-period select changes and both spacings. Directed checks pin down the patterns at counts 9 and 12.

// File: rtl/byteclk_pkg.sv
package byteclk_pkg;

  // 1 when (c - off) mod per falls in the first half of the period
  function automatic logic first_half(input int c, input int off, input int per);
    int r;
    r = (c + per - (off % per)) % per;
    return (r < per / 2);
  endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int PERIOD = 20,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/byte_phase_decode.sv
module byte_phase_decode
  import byteclk_pkg::*;
#(
  parameter int PERIOD = 20,
  parameter int NUM    = 5,
  parameter int SP_N   = 2,
  parameter int SP_W   = 4,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  cnt,
  input  logic           wide,
  output logic [NUM-1:0] lbc
);
  localparam int HALF = PERIOD / 2;

  logic           sp_q;
  logic           sp_use;
  logic [NUM-1:0] lbc_nxt;

  // spacing is only adopted at the start of a byte period
  assign sp_use = (cnt == '0) ? wide : sp_q;

  always_ff @(posedge clk) begin
    if (rst) sp_q <= 1'b0;
    else     sp_q <= sp_use;
  end

  for (genvar k = 0; k < NUM; k++) begin : g_phase
    assign lbc_nxt[k] = first_half(int'(cnt), k * (sp_use ? SP_W : SP_N), PERIOD);
  end

  always_ff @(posedge clk) begin
    if (rst) lbc <= '0;
    else     lbc <= lbc_nxt;
  end

  p_sel_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (sp_q != $past(sp_q)) |-> (cnt == CW'(1)));

  p_first_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1)) |-> lbc[0]);

  p_first_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(HALF + 1)) |-> !lbc[0]);

  if (NUM > 1) begin : g_lag
    p_narrow_lag_r4: assert property (@(posedge clk) disable iff (rst)
      !sp_q |-> (lbc[1] == $past(lbc[0], SP_N)));
    p_wide_lag_r5: assert property (@(posedge clk) disable iff (rst)
      sp_q |-> (lbc[1] == $past(lbc[0], SP_W)));
  end
endmodule

// File: rtl/aux_clock_decode.sv
module aux_clock_decode
  import byteclk_pkg::*;
#(
  parameter int PERIOD   = 20,
  parameter int SYM_HIGH = 4,
  parameter int LEAD     = 2,
  parameter int CW       = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic          bitclk,
  output logic          strobe,
  output logic          symclk
);
  localparam int SYM_PER = PERIOD / 2;

  logic bit_nxt, stb_nxt, sym_nxt;

  always_comb begin
    bit_nxt = ((int'(cnt) % 2) == 1);
    stb_nxt = first_half(int'(cnt), PERIOD - LEAD, PERIOD);
    sym_nxt = ((int'(cnt) % SYM_PER) >= (SYM_PER - SYM_HIGH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitclk <= 1'b0;
      strobe <= 1'b0;
      symclk <= 1'b0;
    end else begin
      bitclk <= bit_nxt;
      strobe <= stb_nxt;
      symclk <= sym_nxt;
    end
  end

  p_strobe_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    ((cnt != CW'(1)) && (strobe != $past(strobe))) |-> $fell(bitclk));
endmodule

// File: rtl/byteclk_gen.sv
module byteclk_gen #(
  parameter int PERIOD   = 20,
  parameter int NUM      = 5,
  parameter int SP_N     = 2,
  parameter int SP_W     = 4,
  parameter int SYM_HIGH = 4,
  parameter int LEAD     = 2
) (
  input  logic           osc_clk,
  input  logic           osc_rst,
  input  logic           phase_wide,
  output logic           bit_clk,
  output logic           load_strobe,
  output logic [NUM-1:0] byte_clk,
  output logic           sym_clk
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;

  phase_counter #(.PERIOD(PERIOD), .CW(CW)) u_cnt (
    .clk (osc_clk),
    .rst (osc_rst),
    .cnt (cnt)
  );

  byte_phase_decode #(
    .PERIOD(PERIOD), .NUM(NUM), .SP_N(SP_N), .SP_W(SP_W), .CW(CW)
  ) u_bytes (
    .clk  (osc_clk),
    .rst  (osc_rst),
    .cnt  (cnt),
    .wide (phase_wide),
    .lbc  (byte_clk)
  );

  aux_clock_decode #(
    .PERIOD(PERIOD), .SYM_HIGH(SYM_HIGH), .LEAD(LEAD), .CW(CW)
  ) u_aux (
    .clk    (osc_clk),
    .rst    (osc_rst),
    .cnt    (cnt),
    .bitclk (bit_clk),
    .strobe (load_strobe),
    .symclk (sym_clk)
  );

  p_sym_fall_r7: assert property (@(posedge osc_clk) disable iff (osc_rst)
    $fell(sym_clk) |-> (byte_clk[0] != $past(byte_clk[0])));

  p_bit_idle_r1: assert property (@(posedge osc_clk)
    osc_rst |=> (!bit_clk && !load_strobe && !sym_clk && (byte_clk == '0)));
endmodule

// File: tb/tb_byteclk_gen.sv
`timescale 1ns/1ps
module tb_byteclk_gen;
  localparam int PERIOD = 20;
  localparam int NUM    = 5;
  localparam int SPN    = 2;
  localparam int SPW    = 4;
  localparam int NVEC   = 8;

  // row: {reset, wide, cycles[7:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd5},  {1'b0, 1'b0, 8'd45}, {1'b0, 1'b1, 8'd50},
    {1'b0, 1'b0, 8'd33}, {1'b0, 1'b1, 8'd7},  {1'b1, 1'b1, 8'd6},
    {1'b0, 1'b1, 8'd60}, {1'b0, 1'b0, 8'd41}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide = 1'b0;
  logic bit_clk, load_strobe, sym_clk;
  logic [NUM-1:0] byte_clk;

  always #2.5 clk = ~clk;

  byteclk_gen dut (
    .osc_clk     (clk),
    .osc_rst     (rst),
    .phase_wide  (wide),
    .bit_clk     (bit_clk),
    .load_strobe (load_strobe),
    .byte_clk    (byte_clk),
    .sym_clk     (sym_clk)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int mc = 0;
  int lastd = -1;
  logic msp = 1'b0;
  logic m_rst = 1'b1;
  logic sp_chg = 1'b0;
  logic ex_bit = 1'b0, ex_stb = 1'b0, ex_sym = 1'b0;
  logic [NUM-1:0] ex_lbc = '0;

  task automatic check(input string tag, input logic [NUM-1:0] act, input logic [NUM-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (decoded count %0d)", tag, act, exp, lastd);
    end
  endtask

  task automatic step(input logic r, input logic w);
    int s;
    rst = r;
    wide = w;
    @(posedge clk);
    m_rst = r;
    sp_chg = 1'b0;
    if (r) begin
      mc = 0; msp = 1'b0; lastd = -1;
      ex_bit = 0; ex_stb = 0; ex_sym = 0; ex_lbc = '0;
    end else begin
      if (mc == 0) begin
        sp_chg = (msp != w);
        msp = w;
      end
      s = msp ? SPW : SPN;
      ex_bit = ((mc % 2) == 1);
      ex_stb = (((mc + 2) % PERIOD) < PERIOD / 2);
      ex_sym = ((mc % 10) >= 6);
      for (int k = 0; k < NUM; k++)
        ex_lbc[k] = (((mc + PERIOD - k * s) % PERIOD) < PERIOD / 2);
      lastd = mc;
      mc = (mc + 1) % PERIOD;
    end
    @(negedge clk);
    if (m_rst) begin
      check("R1 reset outputs", {bit_clk, load_strobe, sym_clk, byte_clk[1:0]}, '0);
      check("R1 reset byte clocks", byte_clk, '0);
    end else begin
      check("R2 bit clock", {4'b0, bit_clk}, {4'b0, ex_bit});
      check("R8 load strobe", {4'b0, load_strobe}, {4'b0, ex_stb});
      check("R7 symbol clock", {4'b0, sym_clk}, {4'b0, ex_sym});
      check("R3 byte clock 0", {4'b0, byte_clk[0]}, {4'b0, ex_lbc[0]});
      if (sp_chg)   check("R6 spacing switch", byte_clk, ex_lbc);
      else if (msp) check("R5 wide spacing", byte_clk, ex_lbc);
      else          check("R4 narrow spacing", byte_clk, ex_lbc);
    end
  endtask

  task automatic run_to(input int d, input logic w);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      step(1'b0, w);
      if (lastd == d) break;
    end
  endtask

  initial begin
    @(negedge clk);
    // table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++) step(VEC[v][9], VEC[v][8]);
    end

    // directed: reset and first edges
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    check("R1 held in reset", {bit_clk, load_strobe, sym_clk, byte_clk[1:0]}, '0);
    step(1'b0, 1'b0);
    check("R3 first rise after release", {4'b0, byte_clk[0]}, 5'b00001);
    check("R2 bit clock low at count 0", {4'b0, bit_clk}, '0);
    check("R8 strobe high at count 0", {4'b0, load_strobe}, 5'b00001);

    // narrow spacing patterns
    run_to(9, 1'b0);
    check("R4 all high at count 9", byte_clk, 5'b11111);
    run_to(12, 1'b0);
    check("R4 pattern at count 12", byte_clk, 5'b11100);

    // wide spacing adopted at next count 0
    run_to(12, 1'b1);
    check("R5 pattern at count 12", byte_clk, 5'b01110);

    // mid-period change ignored until count 0
    run_to(5, 1'b1);
    run_to(12, 1'b0);
    check("R6 mid-period change ignored", byte_clk, 5'b01110);
    run_to(12, 1'b0);
    check("R6 change applied next period", byte_clk, 5'b11100);

    // symbol clock fall lines up with byte clock 0 edge
    run_to(19, 1'b0);
    check("R7 symbol high before wrap", {4'b0, sym_clk}, 5'b00001);
    step(1'b0, 1'b0);
    check("R7 symbol low at byte edge", {3'b0, sym_clk, byte_clk[0]}, 5'b00001);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule